// File: doc/BRIEF.md
# Long Vector Byte Deserializer

This block sits behind an 8b/10b receiver. Each clock it takes one decoded byte, together with a flag that says whether the byte was a control character, plus the decoder's disparity-error and invalid-code flags. From these it rebuilds a vector of `VEC_W` bits that a matching byte serializer on the far end cut into whole bytes. There are no headers. Framing comes only from control characters and an internal byte counter that counts up to `NBYTES = ceil(VEC_W/8)`.

After reset the block is out of sync and ignores data bytes. A control character brings it into synchronization mode and zeroes the byte count. Data bytes then shift in, earliest byte first. When the last byte of a vector arrives, the completed vector is presented for exactly one cycle. The user must capture it during that cycle. A decoder error yields a one-cycle error pulse and throws away the vector in progress.

Top module: `lv_byte_deser`

## Requirements
- R1: While reset is asserted and after its release, `vec_valid`, `rx_err` and `synced` are 0.
- R2: While `synced` is 0, data bytes (`rx_is_ctrl`=0, no error flag) are ignored and never produce `vec_valid`.
- R3: An error-free byte with `rx_is_ctrl`=1 sets `synced` to 1 from the next cycle and zeroes the byte count, and `vec_valid` stays 0 in that next cycle.
- R4: When synced, the byte received first in a vector forms the most significant bits of `vec_out`. The first byte carries the `NBYTES*8-VEC_W` padding bits in its top bits, and these are dropped, so `vec_out` is exactly `VEC_W` bits. With `VEC_W`=20, the bytes 0xFA, 0xBC, 0xDE give 0xABCDE.
- R5: `vec_valid` is high for exactly one cycle: the cycle after the edge that captured the `NBYTES`-th data byte. `vec_out` holds the vector in that cycle.
- R6: A control byte that arrives part-way through a vector discards the partial vector. Counting restarts, so the next `NBYTES` data bytes form a fresh vector.
- R7: A byte with `rx_disp_err` or `rx_code_err` set is not stored. It raises `rx_err` for one cycle in the next cycle and discards the vector in progress. If it lands on what would be the last byte, no `vec_valid` is produced.
- R8: Vectors may follow back to back with no gap. The next vector's first byte may arrive in the cycle right after the previous vector's last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Decoded byte |
| rx_is_ctrl | input | 1 | Byte is a control character |
| rx_disp_err | input | 1 | Decoder disparity error |
| rx_code_err | input | 1 | Decoder invalid-code error |
| vec_out | output | VEC_W | Reassembled vector, valid with `vec_valid` |
| vec_valid | output | 1 | One-cycle completion pulse |
| rx_err | output | 1 | One-cycle error pulse |
| synced | output | 1 | Synchronization mode reached |

## Verification
Completion and error reporting can collide: a decoder error flag can arrive on the very byte that would finish a vector. The bench provokes this directly, and also at random by raising error flags on a small share of cycles while vectors stream back to back. The outcome is judged by requiring an error pulse with no valid pulse. The same holds for a control byte on the last position, which must restart framing silently.

// File: rtl/lv_byte_deser.sv
module lv_byte_deser #(
  parameter int VEC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_byte,
  input  logic             rx_is_ctrl,
  input  logic             rx_disp_err,
  input  logic             rx_code_err,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid,
  output logic             rx_err,
  output logic             synced
);
  localparam int NBYTES = (VEC_W + 7) / 8;
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [VEC_W-1:0] shift_q;
  logic [VEC_W-1:0] shifted;
  logic             bad, take, last;

  assign bad     = rx_disp_err | rx_code_err;
  assign take    = synced & ~bad & ~rx_is_ctrl;
  assign last    = cnt_q == CNT_W'(NBYTES - 1);
  assign shifted = VEC_W'({shift_q, rx_byte});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      shift_q   <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      rx_err    <= 1'b0;
      synced    <= 1'b0;
    end else begin
      vec_valid <= 1'b0;
      rx_err    <= bad;
      if (bad) begin
        cnt_q <= '0;
      end else if (rx_is_ctrl) begin
        synced <= 1'b1;
        cnt_q  <= '0;
      end else if (take) begin
        shift_q <= shifted;
        if (last) begin
          vec_out   <= shifted;
          vec_valid <= 1'b1;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lv_byte_deser_chk.sv
module lv_byte_deser_chk #(
  parameter int VEC_W = 20
) (
  input logic clk,
  input logic rst_n,
  input logic rx_is_ctrl,
  input logic rx_disp_err,
  input logic rx_code_err,
  input logic vec_valid,
  input logic rx_err,
  input logic synced
);
  localparam int NBYTES = (VEC_W + 7) / 8;

  a_r2_unsynced_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |=> !vec_valid);

  a_r3_ctrl_syncs: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_is_ctrl && !rx_disp_err && !rx_code_err) |=> (synced && !vec_valid));

  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_disp_err || rx_code_err) |=> (rx_err && !vec_valid));

  a_r7_err_only_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_disp_err && !rx_code_err) |=> !rx_err);

  a_r3_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    synced |=> synced);

  generate
    if (NBYTES > 1) begin : g_multi
      a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    end
  endgenerate
endmodule

bind lv_byte_deser lv_byte_deser_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/test_lv_byte_deser.sv
module test_lv_byte_deser;
  localparam int VEC_W  = 20;
  localparam int NBYTES = (VEC_W + 7) / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_is_ctrl = 1'b0, rx_disp_err = 1'b0, rx_code_err = 1'b0;
  logic [VEC_W-1:0] vec_out;
  logic vec_valid, rx_err, synced;

  int total = 0, bad = 0, nvec = 0;
  bit done = 0;

  logic [VEC_W-1:0] m_buf = '0, exp_vec = '0;
  int m_cnt = 0;
  bit exp_valid = 0, exp_err = 0, exp_sync = 0;

  always #4 clk = ~clk;

  lv_byte_deser #(.VEC_W(VEC_W)) i_lv_byte_deser (.*);

  function automatic void model(input logic [7:0] b, input bit c, input bit de, input bit ce);
    exp_valid = 0;
    exp_err = 0;
    if (de || ce) begin
      exp_err = 1; m_cnt = 0;
    end else if (c) begin
      exp_sync = 1; m_cnt = 0;
    end else if (exp_sync) begin
      m_buf = VEC_W'({m_buf, b});
      if (m_cnt == NBYTES - 1) begin
        exp_valid = 1; exp_vec = m_buf; m_cnt = 0;
      end else m_cnt++;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic compare(input string req);
    chk(vec_valid == exp_valid, exp_valid ? "R5" : req, "vec_valid", int'(vec_valid), int'(exp_valid));
    chk(rx_err == exp_err, exp_err ? "R7" : req, "rx_err", int'(rx_err), int'(exp_err));
    chk(synced == exp_sync, "R3", "synced", int'(synced), int'(exp_sync));
    if (exp_valid) begin
      nvec++;
      chk(vec_out == exp_vec, "R4", "vec_out", int'(vec_out), int'(exp_vec));
    end
  endtask

  task automatic step(input logic [7:0] b, input bit c, input bit de, input bit ce, input string req);
    @(negedge clk);
    rx_byte = b; rx_is_ctrl = c; rx_disp_err = de; rx_code_err = ce;
    model(b, c, de, ce);
    @(negedge clk);
    compare(req);
  endtask

  task automatic stepq(input logic [7:0] b, input bit c, input bit de, input bit ce, input string req);
    rx_byte = b; rx_is_ctrl = c; rx_disp_err = de; rx_code_err = ce;
    model(b, c, de, ce);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!vec_valid && !rx_err && !synced, "R1", "outputs in reset", {vec_valid, rx_err, synced}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!vec_valid && !rx_err && !synced, "R1", "outputs after reset", {vec_valid, rx_err, synced}, 0);

    for (int i = 0; i < 5; i++) stepq(8'(i * 37), 0, 0, 0, "R2");
    stepq(8'hBC, 1, 0, 0, "R3");
    stepq(8'hFA, 0, 0, 0, "R4");
    stepq(8'hBC, 0, 0, 0, "R4");
    stepq(8'hDE, 0, 0, 0, "R4");
    chk(exp_vec == 20'hABCDE, "R4", "directed vector", int'(exp_vec), 20'hABCDE);
    // R8: back to back
    stepq(8'h01, 0, 0, 0, "R8");
    stepq(8'h23, 0, 0, 0, "R8");
    stepq(8'h45, 0, 0, 0, "R8");
    // R6: control mid vector
    stepq(8'h11, 0, 0, 0, "R6");
    stepq(8'h22, 0, 0, 0, "R6");
    stepq(8'hBC, 1, 0, 0, "R6");
    stepq(8'h07, 0, 0, 0, "R6");
    stepq(8'h89, 0, 0, 0, "R6");
    stepq(8'hAB, 0, 0, 0, "R6");
    // R7: error on final byte collides with completion
    stepq(8'h31, 0, 0, 0, "R7");
    stepq(8'h32, 0, 0, 0, "R7");
    stepq(8'h33, 0, 1, 0, "R7");
    stepq(8'h34, 0, 0, 0, "R7");
    stepq(8'h35, 0, 0, 0, "R7");
    stepq(8'h36, 0, 0, 1, "R7");
    stepq(8'h0C, 0, 0, 0, "R7");
    stepq(8'h0D, 0, 0, 0, "R7");
    stepq(8'h0E, 0, 0, 0, "R7");
    // control on last position
    stepq(8'h41, 0, 0, 0, "R6");
    stepq(8'h42, 0, 0, 0, "R6");
    stepq(8'hBC, 1, 0, 0, "R6");

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      stepq(8'($urandom), r < 4, r >= 4 && r < 7, r == 7, "R8");
    end
    if (nvec < 20) chk(0, "R8", "too few vectors", nvec, 20);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule